// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This block sits beside one processor and decides which single interrupt is presented to it. It holds one pending slot with a source number and a pending priority, a current processor priority level, and a priority level for inter-processor interrupts (IPIs). A source controller offers interrupts one at a time, each with a source number and a priority. The unit either takes the offer, possibly displacing the source already pending, or bounces it. Any source that loses its place gets a reject notice so that it can try again later.

The processor works the unit through a command port. It can accept the pending interrupt, signal end-of-interrupt, change its current priority level, set the IPI priority, or poll the state. The source side receives single-cycle reject, end-of-interrupt and resend notices. Smaller priority numbers are more favoured. The all-ones priority is the least favoured level and stands for "none". The status word packs the current level in bits 31:24 and the pending source number in bits 23:0. A source number of zero means the slot is empty, and source number 2 is reserved for the IPI.

Top module: `intr_presenter`

## Requirements
- R1: After reset the status word reads 0x00000000, the IPI priority reads 0xFF, the pending priority is 0xFF and `irq_out` is low.
- R2: An offer with priority p is taken only when p is below the current level and either the slot is empty or p is below the pending priority. Taking it loads the source number, sets the pending priority to p and raises `irq_out`. If the displaced source was external, it gets a reject notice carrying its number.
- R3: `irq_out` is high exactly when the slot holds a nonzero source number.
- R4: An offer that is not taken produces a reject notice carrying the offered source number, and the pending slot stays unchanged.
- R5: Accept (op 1) returns the full status word. It then moves the pending priority into the current level, empties the slot, sets the pending priority to 0xFF and lowers `irq_out`.
- R6: Setting the level (op 3, value in data bits 7:0) to a value below the old level displaces a pending source whose pending priority is greater than or equal to the new value. Displacement empties the slot, lowers `irq_out` and rejects the source if it was external. A lower level with nothing to displace produces no notice.
- R7: Setting the level to a value not below the old one while the slot is empty produces a resend pulse. When the IPI priority is below the new level, the IPI is loaded in the same step.
- R8: Setting the IPI priority (op 4, data bits 7:0) runs the IPI check when the new value is below the current level. The check does nothing if a source is pending with a pending priority less than or equal to the IPI priority. Otherwise it rejects any external pending source, loads source 2 with the IPI priority and raises `irq_out`.
- R9: End-of-interrupt (op 2) copies data bits 31:24 into the current level and sends an EOI notice carrying data bits 23:0. If the slot is empty it also requests a resend, running the IPI check against the new level first.
- R10: Poll (op 5) returns the status word and the IPI priority and changes no state.
- R11: Notices and responses are single-cycle pulses that appear in the cycle after the command or offer. An offer made in a cycle that carries a command is ignored, and the source must hold it until a command-free cycle.
- R12: The IPI uses source number 2, and an IPI that is displaced from the slot never produces a reject notice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 3 | Command: 1 accept, 2 EOI, 3 set level, 4 set IPI priority, 5 poll |
| cmd_data | input | 32 | Command operand |
| offer_valid | input | 1 | Source controller offer strobe |
| offer_src | input | 24 | Offered source number (nonzero) |
| offer_prio | input | 8 | Offered priority |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject notice pulse |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | EOI notice pulse |
| eoi_src | output | 24 | Source number being completed |
| resend_req | output | 1 | Resend request pulse to the source side |
| rsp_valid | output | 1 | Accept or poll response pulse |
| rsp_word | output | 32 | Status word returned |
| rsp_ipi | output | 8 | IPI priority returned |

## Verification
Offers are tried in four ways: against an empty slot, against a pending source of better, equal and worse priority, and against a level that already blocks them. This separates a strict compare from a non-strict one and shows whether a take or a bounce was chosen. The IPI is driven through three paths: a blocked check, a check that displaces an external source, and a check triggered from a resend. An IPI that is later displaced shows whether rejects are wrongly sent to a non-external owner. Level changes cover a higher level with an empty slot, a lower level that stops short of the pending priority, and a lower level that reaches it. These tell displacement apart from the resend path.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_ACCEPT    = 3'd1,
    OP_EOI       = 3'd2,
    OP_SET_LEVEL = 3'd3,
    OP_SET_IPI   = 3'd4,
    OP_POLL      = 3'd5
  } ipc_op_e;
endpackage

// File: rtl/ipc_rst_sync.sv
module ipc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ipc_offer_eval.sv
module ipc_offer_eval #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic [PRIO_W-1:0] cur_level,
  input  logic [SRC_W-1:0]  pend_src,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              pend_ext,
  output logic              take,
  output logic              bump_rej
);
  logic occupied;
  logic blocked;

  always_comb begin
    occupied = (pend_src != '0);
    blocked  = (offer_prio >= cur_level) || (occupied && (pend_prio <= offer_prio));
    take     = !blocked;
    bump_rej = take && occupied && pend_ext;
  end
endmodule

// File: rtl/ipc_ipi_eval.sv
module ipc_ipi_eval #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cand_ipi,
  input  logic [PRIO_W-1:0] cand_level,
  input  logic [SRC_W-1:0]  pend_src,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              pend_ext,
  output logic              fire,
  output logic              bump_rej
);
  logic occupied;
  logic held_off;

  always_comb begin
    occupied = (pend_src != '0);
    held_off = occupied && (pend_prio <= cand_ipi);
    fire     = (cand_ipi < cand_level) && !held_off;
    bump_rej = fire && occupied && pend_ext;
  end
endmodule

// File: rtl/ipc_pulse_reg.sv
module ipc_pulse_reg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] data,
  output logic         valid,
  output logic [W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      data_q <= '0;
    end else begin
      valid <= fire;
      if (fire) data_q <= data;
    end
  end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  output logic              irq_out,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              resend_req,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_word,
  output logic [PRIO_W-1:0] rsp_ipi
);
  import ipc_pkg::*;

  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);
  localparam int                RSP_W     = WORD_W + PRIO_W;

  logic rst_n_int;

  logic [PRIO_W-1:0] cur_level_q, cur_level_d;
  logic [SRC_W-1:0]  pend_src_q,  pend_src_d;
  logic [PRIO_W-1:0] pend_prio_q, pend_prio_d;
  logic [PRIO_W-1:0] ipi_prio_q,  ipi_prio_d;
  logic              pend_ext_q,  pend_ext_d;
  logic              irq_q,       irq_d;
  logic              resend_q,    resend_d;
  logic              state_en;

  logic              rej_fire;
  logic [SRC_W-1:0]  rej_data;
  logic              eoi_fire;
  logic              rsp_fire;
  logic [RSP_W-1:0]  rsp_data;
  logic [RSP_W-1:0]  rsp_q;

  ipc_op_e           op;
  logic [PRIO_W-1:0] cand_level;
  logic [PRIO_W-1:0] cand_ipi;
  logic [PRIO_W-1:0] new_level;
  logic              offer_take, offer_bump;
  logic              ipi_fire,   ipi_bump;

  ipc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // Candidate values the IPI check compares against
  always_comb begin
    op         = ipc_op_e'(cmd_op);
    new_level  = cmd_data[PRIO_W-1:0];
    cand_level = cur_level_q;
    cand_ipi   = ipi_prio_q;
    if (cmd_valid) begin
      if (op == OP_EOI)            cand_level = cmd_data[WORD_W-1:SRC_W];
      else if (op == OP_SET_LEVEL) cand_level = new_level;
      if (op == OP_SET_IPI)        cand_ipi   = cmd_data[PRIO_W-1:0];
    end
  end

  ipc_offer_eval #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_offer (
    .offer_prio (offer_prio),
    .cur_level  (cur_level_q),
    .pend_src   (pend_src_q),
    .pend_prio  (pend_prio_q),
    .pend_ext   (pend_ext_q),
    .take       (offer_take),
    .bump_rej   (offer_bump)
  );

  ipc_ipi_eval #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ipi (
    .cand_ipi   (cand_ipi),
    .cand_level (cand_level),
    .pend_src   (pend_src_q),
    .pend_prio  (pend_prio_q),
    .pend_ext   (pend_ext_q),
    .fire       (ipi_fire),
    .bump_rej   (ipi_bump)
  );

  // Next-state logic
  always_comb begin
    cur_level_d = cur_level_q;
    pend_src_d  = pend_src_q;
    pend_prio_d = pend_prio_q;
    ipi_prio_d  = ipi_prio_q;
    pend_ext_d  = pend_ext_q;
    irq_d       = irq_q;
    resend_d    = 1'b0;
    rej_fire    = 1'b0;
    rej_data    = pend_src_q;
    eoi_fire    = 1'b0;
    rsp_fire    = 1'b0;
    rsp_data    = {cur_level_q, pend_src_q, ipi_prio_q};
    state_en    = cmd_valid || offer_valid;

    if (cmd_valid) begin
      case (op)
        OP_ACCEPT: begin
          rsp_fire    = 1'b1;
          cur_level_d = pend_prio_q;
          pend_src_d  = '0;
          pend_prio_d = PRIO_NONE;
          pend_ext_d  = 1'b0;
          irq_d       = 1'b0;
        end
        OP_POLL: begin
          rsp_fire = 1'b1;
        end
        OP_SET_IPI: begin
          ipi_prio_d = cand_ipi;
          if (ipi_fire) begin
            rej_fire    = ipi_bump;
            pend_src_d  = IPI_NUM;
            pend_prio_d = cand_ipi;
            pend_ext_d  = 1'b0;
            irq_d       = 1'b1;
          end
        end
        OP_SET_LEVEL: begin
          cur_level_d = new_level;
          if (new_level < cur_level_q) begin
            if ((pend_src_q != '0) && (new_level <= pend_prio_q)) begin
              rej_fire    = pend_ext_q;
              pend_src_d  = '0;
              pend_prio_d = PRIO_NONE;
              pend_ext_d  = 1'b0;
              irq_d       = 1'b0;
            end
          end else if (pend_src_q == '0) begin
            resend_d = 1'b1;
            if (ipi_fire) begin
              pend_src_d  = IPI_NUM;
              pend_prio_d = cand_ipi;
              pend_ext_d  = 1'b0;
              irq_d       = 1'b1;
            end
          end
        end
        OP_EOI: begin
          cur_level_d = cmd_data[WORD_W-1:SRC_W];
          eoi_fire    = 1'b1;
          if (pend_src_q == '0) begin
            resend_d = 1'b1;
            if (ipi_fire) begin
              pend_src_d  = IPI_NUM;
              pend_prio_d = cand_ipi;
              pend_ext_d  = 1'b0;
              irq_d       = 1'b1;
            end
          end
        end
        default: begin
        end
      endcase
    end else if (offer_valid) begin
      if (offer_take) begin
        rej_fire    = offer_bump;
        pend_src_d  = offer_src;
        pend_prio_d = offer_prio;
        pend_ext_d  = 1'b1;
        irq_d       = 1'b1;
      end else begin
        rej_fire = 1'b1;
        rej_data = offer_src;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cur_level_q <= '0;
      pend_src_q  <= '0;
      pend_prio_q <= PRIO_NONE;
      ipi_prio_q  <= PRIO_NONE;
      pend_ext_q  <= 1'b0;
      irq_q       <= 1'b0;
      resend_q    <= 1'b0;
    end else begin
      resend_q <= resend_d;
      if (state_en) begin
        cur_level_q <= cur_level_d;
        pend_src_q  <= pend_src_d;
        pend_prio_q <= pend_prio_d;
        ipi_prio_q  <= ipi_prio_d;
        pend_ext_q  <= pend_ext_d;
        irq_q       <= irq_d;
      end
    end
  end

  ipc_pulse_reg #(.W(SRC_W)) u_rej (
    .clk (clk), .rst_n (rst_n_int), .fire (rej_fire), .data (rej_data),
    .valid (rej_valid), .data_q (rej_src)
  );

  ipc_pulse_reg #(.W(SRC_W)) u_eoi (
    .clk (clk), .rst_n (rst_n_int), .fire (eoi_fire), .data (cmd_data[SRC_W-1:0]),
    .valid (eoi_valid), .data_q (eoi_src)
  );

  ipc_pulse_reg #(.W(RSP_W)) u_rsp (
    .clk (clk), .rst_n (rst_n_int), .fire (rsp_fire), .data (rsp_data),
    .valid (rsp_valid), .data_q (rsp_q)
  );

  assign rsp_word   = rsp_q[RSP_W-1:PRIO_W];
  assign rsp_ipi    = rsp_q[PRIO_W-1:0];
  assign irq_out    = irq_q;
  assign resend_req = resend_q;
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [WORD_W-1:0] cmd_data,
  input logic              offer_valid,
  input logic [SRC_W-1:0]  offer_src,
  input logic [PRIO_W-1:0] offer_prio,
  input logic              irq_out,
  input logic              rej_valid,
  input logic [SRC_W-1:0]  rej_src,
  input logic              eoi_valid,
  input logic [SRC_W-1:0]  eoi_src,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] rsp_word,
  input logic [SRC_W-1:0]  pend_src_q,
  input logic [PRIO_W-1:0] pend_prio_q,
  input logic [PRIO_W-1:0] cur_level_q
);
  import ipc_pkg::*;

  a_r3_irq_follows_slot: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (pend_src_q != '0));

  a_r5_empty_slot_none_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_src_q == '0) |-> (pend_prio_q == '1));

  a_r4_blocked_offer_bounced: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !cmd_valid && (offer_prio >= cur_level_q))
      |=> (rej_valid && (rej_src == $past(offer_src)) && $stable(pend_src_q)));

  a_r5_accept_returns_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_ACCEPT))
      |=> (!irq_out && rsp_valid && (rsp_word == {$past(cur_level_q), $past(pend_src_q)})));

  a_r9_eoi_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_EOI))
      |=> (eoi_valid && (eoi_src == $past(cmd_data[SRC_W-1:0]))
           && (cur_level_q == $past(cmd_data[WORD_W-1:SRC_W]))));

  a_r10_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_POLL))
      |=> ($stable(pend_src_q) && $stable(cur_level_q) && !rej_valid));

  a_r11_idle_no_notice: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !offer_valid) |=> (!rej_valid && !eoi_valid && !rsp_valid));
endmodule

bind intr_presenter ipc_checker #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ipc_checker (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_data    (cmd_data),
  .offer_valid (offer_valid),
  .offer_src   (offer_src),
  .offer_prio  (offer_prio),
  .irq_out     (irq_out),
  .rej_valid   (rej_valid),
  .rej_src     (rej_src),
  .eoi_valid   (eoi_valid),
  .eoi_src     (eoi_src),
  .rsp_valid   (rsp_valid),
  .rsp_word    (rsp_word),
  .pend_src_q  (pend_src_q),
  .pend_prio_q (pend_prio_q),
  .cur_level_q (cur_level_q)
);

// File: tb/intr_presenter_test.sv
`timescale 1ns/1ps
module intr_presenter_test;
  import ipc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_data;
  logic        offer_valid;
  logic [23:0] offer_src;
  logic [7:0]  offer_prio;
  logic        irq_out, rej_valid, eoi_valid, resend_req, rsp_valid;
  logic [23:0] rej_src, eoi_src;
  logic [31:0] rsp_word;
  logic [7:0]  rsp_ipi;

  int checks = 0;
  int errors = 0;

  logic        c_rej_v, c_eoi_v, c_rsd, c_rsp_v, c_irq;
  logic [23:0] c_rej_src, c_eoi_src;
  logic [31:0] c_word;
  logic [7:0]  c_ipi;

  always #10 clk = ~clk;

  intr_presenter uut (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_data (cmd_data),
    .offer_valid (offer_valid), .offer_src (offer_src), .offer_prio (offer_prio),
    .irq_out (irq_out), .rej_valid (rej_valid), .rej_src (rej_src),
    .eoi_valid (eoi_valid), .eoi_src (eoi_src), .resend_req (resend_req),
    .rsp_valid (rsp_valid), .rsp_word (rsp_word), .rsp_ipi (rsp_ipi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic capture();
    c_rej_v = rej_valid; c_rej_src = rej_src; c_eoi_v = eoi_valid; c_eoi_src = eoi_src;
    c_rsd = resend_req; c_rsp_v = rsp_valid; c_word = rsp_word; c_ipi = rsp_ipi; c_irq = irq_out;
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = '0;
    offer_valid = 1'b0; offer_src = '0; offer_prio = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_cmd(input ipc_op_e op, input logic [31:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    capture();
  endtask

  task automatic do_offer(input logic [23:0] src, input logic [7:0] prio);
    @(negedge clk);
    offer_valid = 1'b1; offer_src = src; offer_prio = prio;
    @(negedge clk);
    offer_valid = 1'b0;
    capture();
  endtask

  task automatic poll_word(output logic [31:0] w, output logic [7:0] ipi);
    do_cmd(OP_POLL, 32'h0);
    w = c_word; ipi = c_ipi;
  endtask

  task automatic t_reset_state();
    logic [31:0] w; logic [7:0] ipi;
    do_reset();
    chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    poll_word(w, ipi);
    chk("R1 word after reset", w, 32'h0);
    chk("R1 ipi prio after reset", {24'd0, ipi}, 32'hFF);
    chk("R10 poll response valid", {31'd0, c_rsp_v}, 32'd1);
  endtask

  task automatic t_offers();
    logic [31:0] w; logic [7:0] ipi;
    do_reset();
    do_offer(24'h123, 8'h05);
    chk("R4 offer at level 0 rejected", {31'd0, c_rej_v}, 32'd1);
    chk("R4 rejected src", {8'd0, c_rej_src}, 32'h123);
    chk("R4 irq stays low", {31'd0, c_irq}, 32'd0);
    do_cmd(OP_SET_LEVEL, 32'hFF);
    chk("R7 resend on raised level", {31'd0, c_rsd}, 32'd1);
    chk("R7 no ipi at FF", {31'd0, c_irq}, 32'd0);
    do_offer(24'h40, 8'h10);
    chk("R2 offer taken no reject", {31'd0, c_rej_v}, 32'd0);
    chk("R2 irq raised", {31'd0, c_irq}, 32'd1);
    poll_word(w, ipi);
    chk("R2 word after take", w, 32'hFF000040);
    do_offer(24'h41, 8'h20);
    chk("R4 worse offer rejected", {7'd0, c_rej_v, c_rej_src}, {8'h01, 24'h41});
    do_offer(24'h42, 8'h10);
    chk("R4 equal offer rejected", {7'd0, c_rej_v, c_rej_src}, {8'h01, 24'h42});
    poll_word(w, ipi);
    chk("R4 slot unchanged", w, 32'hFF000040);
    do_offer(24'h43, 8'h08);
    chk("R2 displaced external rejected", {7'd0, c_rej_v, c_rej_src}, {8'h01, 24'h40});
    do_cmd(OP_ACCEPT, 32'h0);
    chk("R5 accept word", c_word, 32'hFF000043);
    chk("R5 accept lowers irq", {31'd0, c_irq}, 32'd0);
    poll_word(w, ipi);
    chk("R5 level takes pending prio", w, 32'h08000000);
    do_offer(24'h44, 8'h08);
    chk("R4 offer at level rejected", {7'd0, c_rej_v, c_rej_src}, {8'h01, 24'h44});
    do_cmd(OP_EOI, 32'hFF000043);
    chk("R9 eoi notice", {7'd0, c_eoi_v, c_eoi_src}, {8'h01, 24'h43});
    chk("R9 resend when empty", {31'd0, c_rsd}, 32'd1);
    poll_word(w, ipi);
    chk("R9 level restored", w, 32'hFF000000);
  endtask

  task automatic t_level_displace();
    logic [31:0] w; logic [7:0] ipi;
    do_reset();
    do_cmd(OP_SET_LEVEL, 32'hFF);
    do_offer(24'h50, 8'h30);
    do_cmd(OP_SET_LEVEL, 32'h40);
    chk("R6 lower level short of pending keeps source", {31'd0, c_irq}, 32'd1);
    chk("R6 no reject", {31'd0, c_rej_v}, 32'd0);
    poll_word(w, ipi);
    chk("R6 word", w, 32'h40000050);
    do_cmd(OP_SET_LEVEL, 32'h30);
    chk("R6 displaced reject", {7'd0, c_rej_v, c_rej_src}, {8'h01, 24'h50});
    chk("R6 irq lowered", {31'd0, c_irq}, 32'd0);
    do_cmd(OP_SET_LEVEL, 32'h20);
    chk("R6 lower level empty no resend", {30'd0, c_rsd, c_rej_v}, 32'd0);
    poll_word(w, ipi);
    chk("R6 final word", w, 32'h20000000);
  endtask

  task automatic t_ipi();
    logic [31:0] w; logic [7:0] ipi;
    do_reset();
    do_cmd(OP_SET_LEVEL, 32'hFF);
    do_offer(24'h60, 8'h40);
    do_cmd(OP_SET_IPI, 32'h50);
    chk("R8 blocked ipi no reject", {31'd0, c_rej_v}, 32'd0);
    poll_word(w, ipi);
    chk("R8 blocked ipi keeps slot", w, 32'hFF000060);
    chk("R10 poll ipi prio", {24'd0, ipi}, 32'h50);
    do_cmd(OP_SET_IPI, 32'h20);
    chk("R8 ipi rejects external", {7'd0, c_rej_v, c_rej_src}, {8'h01, 24'h60});
    poll_word(w, ipi);
    chk("R12 ipi source number", w, 32'hFF000002);
    do_offer(24'h61, 8'h10);
    chk("R12 displaced ipi not rejected", {31'd0, c_rej_v}, 32'd0);
    chk("R2 irq high after take", {31'd0, c_irq}, 32'd1);
    do_cmd(OP_SET_IPI, 32'h05);
    chk("R8 stronger ipi displaces", {7'd0, c_rej_v, c_rej_src}, {8'h01, 24'h61});
    do_cmd(OP_SET_LEVEL, 32'h05);
    chk("R12 level displaces ipi silently", {31'd0, c_rej_v}, 32'd0);
    chk("R6 irq low after displacement", {31'd0, c_irq}, 32'd0);
    poll_word(w, ipi);
    chk("R6 word after ipi displacement", w, 32'h05000000);
  endtask

  task automatic t_resend_ipi();
    logic [31:0] w; logic [7:0] ipi;
    do_reset();
    do_cmd(OP_SET_IPI, 32'h30);
    chk("R8 ipi not below level idle", {31'd0, c_irq}, 32'd0);
    do_cmd(OP_EOI, 32'hFF000000);
    chk("R9 resend pulse", {31'd0, c_rsd}, 32'd1);
    chk("R7 ipi loaded by resend", {31'd0, c_irq}, 32'd1);
    do_cmd(OP_ACCEPT, 32'h0);
    chk("R5 accept ipi word", c_word, 32'hFF000002);
    poll_word(w, ipi);
    chk("R5 level from ipi prio", w, 32'h30000000);
  endtask

  task automatic t_pulses();
    logic [31:0] w; logic [7:0] ipi;
    do_reset();
    do_cmd(OP_SET_LEVEL, 32'hFF);
    do_offer(24'h70, 8'h90);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = OP_POLL; cmd_data = '0;
    offer_valid = 1'b1; offer_src = 24'h71; offer_prio = 8'h01;
    @(negedge clk);
    cmd_valid = 1'b0; offer_valid = 1'b0;
    capture();
    chk("R11 offer ignored during command", c_word, 32'hFF000070);
    chk("R11 no reject for ignored offer", {31'd0, c_rej_v}, 32'd0);
    do_offer(24'h72, 8'hF0);
    chk("R4 reject pulse", {31'd0, c_rej_v}, 32'd1);
    @(negedge clk);
    chk("R11 reject lasts one cycle", {31'd0, rej_valid}, 32'd0);
    chk("R11 response lasts one cycle", {31'd0, rsp_valid}, 32'd0);
    poll_word(w, ipi);
    chk("R3 irq matches slot", {31'd0, c_irq}, {31'd0, w[23:0] != 24'd0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_offers();
    t_level_displace();
    t_ipi();
    t_resend_ipi();
    t_pulses();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule